// File: doc/BRIEF.md
# Polled Command Byte Sequencer

This engine moves one command packet from the host side into a disk controller's data register and then collects the controller's result bytes. The host places up to `MAX_CMD` command bytes in a flat buffer and gives the number of bytes to send and the number of result bytes to expect. It then pulses `start`. Before every single byte transfer, in either direction, the engine reads the controller's main status register over a simple register bus. A byte moves only when both the ready flag and the direction flag agree with the current phase.

If the controller is not ready, the engine waits a fixed gap and polls again. The gap is a cycle count derived from the clock rate and a microsecond figure. After the last permitted poll fails, the whole packet is abandoned and an error pulse is raised. On success a done pulse is raised. The captured result bytes are then held on `res_buf`, and a pass flag reflects the two-bit completion code in the top bits of the first result byte.

The register bus uses one-cycle strobes. Read data is returned registered, in the cycle after a read strobe. A status poll and a data read are separate transactions.

Top module: `poll_cmd_seq`

## Requirements
- R1: A write strobe to the data address is issued only after the status byte just polled showed ready (bit 7) set and direction (bit 6) clear.
- R2: A read strobe to the data address is issued only after the status byte just polled showed ready (bit 7) set and direction (bit 6) set. A status that is ready but shows the wrong direction counts as not ready.
- R3: Each byte transfer uses at most `POLL_TRIES` (5) status polls. If the controller reports not ready for k < 5 polls, exactly k+1 polls precede the transfer.
- R4: When the fifth poll for a byte fails, `err` pulses and `busy` drops. No further data transfer of that packet takes place, and `res_ok` reads 0.
- R5: Consecutive status polls for the same byte are spaced exactly `TICKS_PER_US*GAP_US + 2` cycles apart, strobe to strobe.
- R6: Command byte i is taken from `cmd_buf[8i+7:8i]`. Command bytes are sent in order from index 0 to `cmd_len-1`, then `res_len` result bytes are read. Result byte j is captured into `res_buf[8j+7:8j]`.
- R7: At done, `res_ok` is 1 exactly when `res_len` > 0 and bits [7:6] of the first result byte equal 2'b00 (normal termination).
- R8: `start` is acted upon only when idle. `busy` is high from the cycle after an accepted start until the cycle in which `done` or `err` pulses. `done` and `err` each last one cycle and never coincide.
- R9: After reset `busy`, `done`, `err`, `res_ok` and `res_buf` are 0, and no bus strobe is active.
- R10: A zero `cmd_len` skips the command phase. When both lengths are zero, `done` pulses in the cycle after `start` with no bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (honoured only when idle) |
| cmd_len | input | $clog2(MAX_CMD+1) | Number of command bytes to send |
| res_len | input | $clog2(MAX_RES+1) | Number of result bytes to collect |
| cmd_buf | input | MAX_CMD*DW | Command bytes, byte i at [DW*i +: DW] |
| bus_addr | output | AW | Register bus address (status or data) |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_wdata | output | DW | Write data (current command byte) |
| bus_rdata | input | DW | Registered read data, valid the cycle after `bus_rd` |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| res_ok | output | 1 | Completion code of the first result byte was normal |
| res_buf | output | MAX_RES*DW | Captured result bytes, byte j at [DW*j +: DW] |

## Verification
The bench sweeps every combination of command and result length against a controller model. The model stalls each byte for between zero and four polls, so the off-by-one at the retry limit is reached on many bytes. A sequencer that allowed one poll too few would time out on the four-stall bytes, and one that allowed one too many would miss the abort. The bench also plants a permanent stall, and separately a ready status with the wrong direction, at every byte position of several packets. It checks that nothing moves after the error pulse: a design that trusted the ready flag alone would write into a controller that is talking back. The bench also measures the strobe-to-strobe poll spacing, fires a second start in mid-packet, and varies the completion code of the first result byte, including the single-result case where the flag must be formed from the byte being captured.

// File: rtl/poll_cmd_seq.sv
module poll_cmd_seq #(
  parameter int DW = 8,
  parameter int MAX_CMD = 9,
  parameter int MAX_RES = 7,
  parameter int POLL_TRIES = 5,
  parameter int TICKS_PER_US = 125,
  parameter int GAP_US = 50,
  parameter int AW = 3,
  parameter logic [AW-1:0] STAT_ADDR = AW'(4),
  parameter logic [AW-1:0] DATA_ADDR = AW'(5),
  parameter int RDY_BIT = 7,
  parameter int DIR_BIT = 6,
  parameter logic [1:0] LCS_NORMAL = 2'b00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(MAX_CMD+1)-1:0]  cmd_len,
  input  logic [$clog2(MAX_RES+1)-1:0]  res_len,
  input  logic [MAX_CMD*DW-1:0]         cmd_buf,
  output logic [AW-1:0]                 bus_addr,
  output logic                          bus_rd,
  output logic                          bus_wr,
  output logic [DW-1:0]                 bus_wdata,
  input  logic [DW-1:0]                 bus_rdata,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic                          res_ok,
  output logic [MAX_RES*DW-1:0]         res_buf
);

  localparam int IDX_W   = $clog2((MAX_CMD > MAX_RES ? MAX_CMD : MAX_RES) + 1);
  localparam int TRY_W   = $clog2(POLL_TRIES + 1);
  localparam int GAP_CYC = (TICKS_PER_US * GAP_US > 0) ? TICKS_PER_US * GAP_US : 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_EVAL, S_GAP, S_WR, S_RD, S_CAPT, S_DONE, S_ERR
  } state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx, cl_q, rl_q;
  logic              phase_rd;
  logic [TRY_W-1:0]  tries;
  logic [GAP_W-1:0]  gap_cnt;
  logic              stat_rdy_q, stat_dir_q;
  logic              ok_q;
  logic [DW-1:0]     rq [MAX_RES];

  wire poll_ok  = bus_rdata[RDY_BIT] && (bus_rdata[DIR_BIT] == phase_rd);
  wire last_try = (tries == TRY_W'(POLL_TRIES - 1));
  wire last_cmd = ((idx + IDX_W'(1)) == cl_q);
  wire last_res = ((idx + IDX_W'(1)) == rl_q);

  assign bus_rd   = (state == S_POLL) || (state == S_RD);
  assign bus_wr   = (state == S_WR);
  assign bus_addr = (state == S_WR || state == S_RD) ? DATA_ADDR : STAT_ADDR;
  assign busy     = (state != S_IDLE) && (state != S_DONE) && (state != S_ERR);
  assign done     = (state == S_DONE);
  assign err      = (state == S_ERR);
  assign res_ok   = ok_q;

  always_comb begin
    bus_wdata = '0;
    for (int k = 0; k < MAX_CMD; k++)
      if (idx == IDX_W'(k)) bus_wdata = cmd_buf[k*DW +: DW];
  end

  for (genvar g = 0; g < MAX_RES; g++) begin : g_res
    assign res_buf[g*DW +: DW] = rq[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      cl_q       <= '0;
      rl_q       <= '0;
      phase_rd   <= 1'b0;
      tries      <= '0;
      gap_cnt    <= '0;
      stat_rdy_q <= 1'b0;
      stat_dir_q <= 1'b0;
      ok_q       <= 1'b0;
      for (int k = 0; k < MAX_RES; k++) rq[k] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cl_q  <= IDX_W'(cmd_len);
          rl_q  <= IDX_W'(res_len);
          idx   <= '0;
          tries <= '0;
          ok_q  <= 1'b0;
          for (int k = 0; k < MAX_RES; k++) rq[k] <= '0;
          if (cmd_len != '0) begin
            phase_rd <= 1'b0;
            state    <= S_POLL;
          end else if (res_len != '0) begin
            phase_rd <= 1'b1;
            state    <= S_POLL;
          end else begin
            state    <= S_DONE;
          end
        end
        S_POLL: state <= S_EVAL;
        S_EVAL: begin
          stat_rdy_q <= bus_rdata[RDY_BIT];
          stat_dir_q <= bus_rdata[DIR_BIT];
          if (poll_ok) begin
            tries <= '0;
            state <= phase_rd ? S_RD : S_WR;
          end else if (last_try) begin
            ok_q  <= 1'b0;
            state <= S_ERR;
          end else begin
            tries   <= tries + TRY_W'(1);
            gap_cnt <= GAP_W'(GAP_CYC - 1);
            state   <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) state <= S_POLL;
          else gap_cnt <= gap_cnt - GAP_W'(1);
        end
        S_WR: begin
          if (last_cmd) begin
            idx <= '0;
            if (rl_q != '0) begin
              phase_rd <= 1'b1;
              state    <= S_POLL;
            end else begin
              state    <= S_DONE;
            end
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_POLL;
          end
        end
        S_RD: state <= S_CAPT;
        S_CAPT: begin
          for (int k = 0; k < MAX_RES; k++)
            if (idx == IDX_W'(k)) rq[k] <= bus_rdata;
          if (idx == '0) ok_q <= (bus_rdata[DW-1:DW-2] == LCS_NORMAL);
          if (last_res) begin
            state <= S_DONE;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_POLL;
          end
        end
        S_DONE:  state <= S_IDLE;
        S_ERR:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WR_NEEDS_OUTBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (stat_rdy_q && !stat_dir_q)); // R1

  AST_RD_NEEDS_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_ADDR) |-> (stat_rdy_q && stat_dir_q)); // R2

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(POLL_TRIES)); // R3

  AST_QUIET_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!bus_wr && !bus_rd && !res_ok)); // R4

  AST_POLL_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR) |=> (!bus_rd && !bus_wr)); // R5

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> (!done && !err && !busy)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr})); // R9

endmodule

// File: tb/poll_cmd_seq_bench.sv
`timescale 1ns/1ps
module poll_cmd_seq_bench;
  localparam int MAX_CMD = 9;
  localparam int MAX_RES = 7;
  localparam int GAP = 3;
  localparam logic [2:0] STAT_A = 3'd4;
  localparam logic [2:0] DATA_A = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cmd_len = '0;
  logic [2:0] res_len = '0;
  logic [MAX_CMD*8-1:0] cmd_buf = '0;
  logic [2:0] bus_addr;
  logic bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = '0;
  logic busy, done, err, res_ok;
  logic [MAX_RES*8-1:0] res_buf;

  always #4 clk = ~clk;

  poll_cmd_seq #(.MAX_CMD(MAX_CMD), .MAX_RES(MAX_RES), .TICKS_PER_US(1), .GAP_US(GAP)) u_poll_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .res_len(res_len),
    .cmd_buf(cmd_buf), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .err(err), .res_ok(res_ok), .res_buf(res_buf));

  int checks = 0, fails = 0, cyc = 0;
  int m_cl = 0, m_rl = 0, m_seed = 0, m_fail_at = -1, m_mode = 0;
  int xfer_n = 0, polls_this = 0, last_poll = 0, proto_bad = 0, spacing_bad = 0, traffic = 0;
  int polls_used [16];
  logic [7:0] wr_log [MAX_CMD];

  function automatic int stall_of(int n, int seed);
    return (n * 3 + seed) % 5;
  endfunction
  function automatic logic [7:0] cmd_b(int i, int seed);
    return 8'((i * 37 + seed * 11 + 5) % 256);
  endfunction
  function automatic logic [7:0] res_b(int j, int seed);
    if (j == 0) return 8'(((seed % 4) << 6) | ((seed * 5) % 64));
    return 8'((j * 53 + seed * 7 + 9) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // controller model
  always @(posedge clk) begin
    cyc++;
    if (bus_rd || bus_wr) traffic++;
    if (bus_rd && bus_addr == STAT_A) begin
      logic exp_dir, rdy;
      exp_dir = (xfer_n >= m_cl);
      if (polls_this > 0 && (cyc - last_poll) != GAP + 2) spacing_bad++;
      last_poll = cyc;
      if (xfer_n == m_fail_at) begin
        if (m_mode == 2) bus_rdata <= {1'b1, ~exp_dir, 6'b0};
        else             bus_rdata <= {1'b0, exp_dir, 6'b0};
      end else begin
        rdy = (polls_this >= stall_of(xfer_n, m_seed));
        bus_rdata <= {rdy, exp_dir, 6'b0};
      end
      polls_this++;
    end else if (bus_rd && bus_addr == DATA_A) begin
      if (xfer_n < m_cl) proto_bad++;
      bus_rdata <= res_b(xfer_n - m_cl, m_seed);
      if (xfer_n < 16) polls_used[xfer_n] = polls_this;
      xfer_n++;
      polls_this = 0;
    end
    if (bus_wr) begin
      if (xfer_n >= m_cl || bus_addr != DATA_A) proto_bad++;
      else wr_log[xfer_n] = bus_wdata;
      if (xfer_n < 16) polls_used[xfer_n] = polls_this;
      xfer_n++;
      polls_this = 0;
    end
  end

  task automatic run_case(input int cl, input int rl, input int seed, input int fail_at, input int mode);
    int n;
    bit ok;
    m_cl = cl; m_rl = rl; m_seed = seed; m_fail_at = fail_at; m_mode = mode;
    xfer_n = 0; polls_this = 0; proto_bad = 0; spacing_bad = 0; traffic = 0;
    for (int i = 0; i < MAX_CMD; i++) cmd_buf[i*8 +: 8] = cmd_b(i, seed);
    cmd_len = 4'(cl);
    res_len = 3'(rl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cl + rl == 0) begin
      chk(done && !busy && traffic == 0, "R10 empty packet done at once", int'(done), 1);
      @(negedge clk);
      chk(!done && !busy, "R8 done lasts one cycle", int'(done), 0);
      return;
    end
    chk(busy, "R8 busy after start", int'(busy), 1);
    if (seed % 2 == 1) begin
      // second start mid-packet must be ignored
      @(negedge clk);
      cmd_len = 4'd1; res_len = 3'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && !err && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (fail_at < 0) begin
      chk(done && !err && !busy, "R8 done pulse without err", int'(err), 0);
      chk(xfer_n == cl + rl, "R6 transfer count", xfer_n, cl + rl);
      ok = 1;
      for (int i = 0; i < cl; i++) if (wr_log[i] !== cmd_b(i, seed)) ok = 0;
      chk(ok, "R6 command bytes in order", cl, cl);
      ok = 1;
      for (int j = 0; j < rl; j++) if (res_buf[j*8 +: 8] !== res_b(j, seed)) ok = 0;
      chk(ok, "R6 result bytes captured in order", rl, rl);
      ok = 1;
      for (int t = 0; t < cl + rl; t++) if (polls_used[t] != stall_of(t, seed) + 1) ok = 0;
      chk(ok, "R3 polls per byte equal stall+1", int'(ok), 1);
      chk(spacing_bad == 0, "R5 poll spacing", spacing_bad, 0);
      chk(proto_bad == 0, "R1 R2 direction of data transfers", proto_bad, 0);
      chk(res_ok == (rl > 0 && seed % 4 == 0), "R7 completion code flag",
          int'(res_ok), int'(rl > 0 && seed % 4 == 0));
    end else begin
      chk(err && !done && !busy, "R4 err pulse", int'(err), 1);
      chk(xfer_n == fail_at, "R4 bytes moved before abort", xfer_n, fail_at);
      chk(polls_this == 5, "R3 five polls before giving up", polls_this, 5);
      chk(proto_bad == 0, mode == 2 ? "R2 wrong direction not accepted" : "R1 no transfer when not ready", proto_bad, 0);
      chk(spacing_bad == 0, "R5 poll spacing", spacing_bad, 0);
      n = traffic;
      repeat (4) @(negedge clk);
      chk(traffic == n && !res_ok, "R4 quiet after err", traffic - n, 0);
    end
    @(negedge clk);
    chk(!done && !err && !busy, "R8 pulse lasts one cycle", int'(done | err), 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !res_ok && res_buf == '0, "R9 reset outputs", int'(busy), 0);
    chk(!bus_rd && !bus_wr, "R9 no strobes in reset", int'(bus_rd | bus_wr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && traffic == 0, "R9 idle after reset", traffic, 0);
    for (int cl = 0; cl <= MAX_CMD; cl++)
      for (int rl = 0; rl <= MAX_RES; rl++) begin
        run_case(cl, rl, cl * 8 + rl, -1, 0);
        @(negedge clk);
      end
    for (int mode = 1; mode <= 2; mode++) begin
      for (int f = 0; f < 16; f++) begin run_case(9, 7, 5 + f, f, mode); @(negedge clk); end
      for (int f = 0; f < 5; f++)  begin run_case(3, 2, 2 + f, f, mode); @(negedge clk); end
      for (int f = 0; f < 2; f++)  begin run_case(0, 2, 4 + f, f, mode); @(negedge clk); end
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule